// File: doc/BRIEF.md
# SCSI Target Phase Sequencer

This block is the target side of a SCSI bus once it has won selection. It watches for its own ID bit on the data lines while SEL is asserted and the initiator has released BSY. It then raises BSY and walks the information-transfer phases, signalling each one on the MSG, C/D and I/O lines. Every byte crosses the bus with the REQ/ACK interlock. Command bytes are gathered into an internal descriptor store. Once the descriptor is complete, a decoder chooses the next phase, the transfer length and the block address.

Payload bytes do not stay in the block. In data-in, the bytes come from an external buffer through a valid/ready input port. In data-out, the bytes leave through a valid/ready output port, and the bus handshake stalls while that port is not ready. The decoded block address and byte count are exposed so the buffer can be positioned. A status byte and a message byte close every command, and then the target returns to bus free.

Top module: `scsi_tgt_seq`

## Requirements
- R1: The phase code {msg_o, cd_o, io_o} is 0 for data-out, 1 for data-in, 2 for command, 3 for status, 6 for message-out and 7 for message-in. Bus free and selection drive code 0 with no REQ. The phase code does not change while REQ stays asserted.
- R2: From bus free, the target is selected when sel_i is high, ibsy_i is low and data_i bit ID_BIT (default 6) is high. bsy_o rises on the next clock edge. Any other ID pattern, or a busy initiator, leaves bsy_o low.
- R3: When sel_i falls after selection, the target enters message-out if atn_i is high and command otherwise. One message-out byte always leads to command.
- R4: REQ is raised only while ack_i is low. When REQ and ack_i are both high and the byte can be accepted, the byte moves and REQ is low after the next clock edge.
- R5: The descriptor length comes from opcode bits 7:5. Group 0 uses 6 bytes, groups 1 and 2 use 10, and group 5 uses 12. The reserved groups (3, 4, 6, 7) use 6 bytes and are treated as unsupported. The target stays in command until that many bytes have arrived.
- R6: Opcode 0x00 goes straight to status. Opcodes 0x03, 0x12 and 0x1A go to data-in with byte 4 as the byte count. Opcode 0x15 goes to data-out with byte 4 as the count. Opcode 0x25 goes to data-in with a count of 8.
- R7: For opcode 0x08, lba_o is {byte1[4:0], byte2, byte3} and the count is byte4 × 512, in data-in. For opcodes 0x28 (data-in) and 0x2A (data-out), lba_o is bytes 2 to 5 with byte 2 most significant, and the count is {byte7, byte8} × 512. xfer_len_o shows the decoded count.
- R8: An opcode not listed in R6 or R7 goes directly to status, and message-in returns 0x02. A nonzero LUN (byte 1 bits 7:5) also makes message-in return 0x02, but the phase still follows the opcode. Otherwise message-in returns 0x00.
- R9: After the last data byte, the target enters status. Status sends 0x00, then message-in sends the response code. After the message-in byte, bsy_o is low and the bus is free.
- R10: A data phase decoded with a count of zero is skipped: the next REQ is in status.
- R11: bus_rst_i high forces bus free, with bsy_o and req_o low, after the next edge from any state.
- R12: In data-in, each byte is taken on an in_valid_i/in_ready_o handshake and driven on data_o while REQ is high. In data-out, out_valid_o and out_data_o present the bus byte while REQ and ACK are both high. The transfer holds while out_ready_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst_i | input | 1 | SCSI bus reset line |
| sel_i | input | 1 | Selection line from initiator |
| atn_i | input | 1 | Attention line |
| ack_i | input | 1 | Acknowledge from initiator |
| ibsy_i | input | 1 | Busy driven by the initiator |
| data_i | input | 8 | Data bus as driven by the initiator |
| data_o | output | 8 | Byte the target drives in data-in, status and message-in |
| bsy_o | output | 1 | Target busy |
| req_o | output | 1 | Request |
| msg_o | output | 1 | Phase line MSG |
| cd_o | output | 1 | Phase line C/D |
| io_o | output | 1 | Phase line I/O |
| in_valid_i | input | 1 | Buffer byte available for data-in |
| in_data_i | input | 8 | Buffer byte for data-in |
| in_ready_o | output | 1 | Target takes the buffer byte |
| out_valid_o | output | 1 | Data-out byte present |
| out_data_o | output | 8 | Data-out byte |
| out_ready_i | input | 1 | Buffer accepts the data-out byte |
| lba_o | output | 32 | Decoded block address |
| xfer_len_o | output | 25 | Decoded transfer byte count |

## Verification
The bench targets the descriptor-length boundary. A 12-byte group-5 opcode must keep REQ in command for all twelve bytes; a decoder that used the 6-byte default would answer in status after byte six. It also drives zero-count data commands, where a design that entered data-in anyway would raise a data REQ that never ends. Nonzero LUNs on supported opcodes are checked too: a design that treated these like unsupported opcodes would skip the data phase. A data-out byte is held against a stalled buffer, which shows any design that drops REQ early and loses that byte. A bus reset is applied in the middle of a 512-byte read; a design that ignored it would keep BSY asserted.

// File: rtl/scsi_tgt_pkg.sv
package scsi_tgt_pkg;

   typedef enum logic [3:0] {
      ST_FREE, ST_SELECT, ST_MSGOUT, ST_CMD,
      ST_DOUT, ST_DIN, ST_STATUS, ST_MSGIN
   } tgt_state_t;

   typedef enum logic [1:0] { DIR_NONE, DIR_IN, DIR_OUT } xfer_dir_t;

   localparam logic [7:0] RESP_GOOD  = 8'h00;
   localparam logic [7:0] RESP_CHECK = 8'h02;

   // phase code driven on {MSG, C/D, I/O}
   function automatic logic [2:0] phase_code(input tgt_state_t s);
      case (s)
         ST_DOUT:   return 3'd0;
         ST_DIN:    return 3'd1;
         ST_CMD:    return 3'd2;
         ST_STATUS: return 3'd3;
         ST_MSGOUT: return 3'd6;
         ST_MSGIN:  return 3'd7;
         default:   return 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/tgt_cdb_store.sv
module tgt_cdb_store #(
   parameter int CDB_MAX = 12,
   localparam int CNT_W = $clog2(CDB_MAX + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        wr_en,
   input  logic [7:0]                  wr_byte,
   output logic [CDB_MAX-1:0][7:0]     bytes,
   output logic [CNT_W-1:0]            cnt
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         cnt_q <= '0;
      else if (wr_en && cnt_q != CNT_W'(CDB_MAX))
         cnt_q <= cnt_q + 1'b1;
   end

   for (genvar i = 0; i < CDB_MAX; i++) begin : g_byte
      logic [7:0] b_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr)
            b_q <= '0;
         else if (wr_en && cnt_q == CNT_W'(i))
            b_q <= wr_byte;
      end
      assign bytes[i] = b_q;
   end

   assign cnt = cnt_q;

   // R5
   cdb_cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr && cnt_q == CNT_W'(CDB_MAX)) |=> $stable(cnt));

endmodule

// File: rtl/tgt_cdb_decode.sv
module tgt_cdb_decode
   import scsi_tgt_pkg::*;
#(
   parameter int CDB_MAX   = 12,
   parameter int BLK_SHIFT = 9,
   parameter int LBA_W     = 32,
   localparam int CNT_W    = $clog2(CDB_MAX + 1),
   localparam int LEN_W    = 16 + BLK_SHIFT
) (
   input  logic [CDB_MAX-1:0][7:0] bytes,
   input  logic [CNT_W-1:0]        cnt,
   output logic                    done,
   output xfer_dir_t               dir,
   output logic [LEN_W-1:0]        len,
   output logic [LBA_W-1:0]        lba,
   output logic                    unsup,
   output logic                    lun_nz
);

   logic [7:0]       op;
   logic [2:0]       grp;
   logic [CNT_W-1:0] need;
   logic             unused_hi;

   assign op     = bytes[0];
   assign grp    = op[7:5];
   assign lun_nz = bytes[1][7:5] != 3'd0;
   assign unused_hi = ^{bytes[6], bytes[9], bytes[CDB_MAX-1:10]};

   always_comb begin
      case (grp)
         3'd0:       need = CNT_W'(6);
         3'd1, 3'd2: need = CNT_W'(10);
         3'd5:       need = CNT_W'(12);
         default:    need = CNT_W'(6);
      endcase
   end

   assign done = (cnt == need);

   always_comb begin
      dir   = DIR_NONE;
      len   = '0;
      lba   = '0;
      unsup = 1'b0;
      case (op)
         8'h00: ;
         8'h03, 8'h12, 8'h1A: begin
            dir = DIR_IN;
            len = LEN_W'(bytes[4]);
         end
         8'h15: begin
            dir = DIR_OUT;
            len = LEN_W'(bytes[4]);
         end
         8'h25: begin
            dir = DIR_IN;
            len = LEN_W'(8);
         end
         8'h08: begin
            dir = DIR_IN;
            len = LEN_W'(bytes[4]) << BLK_SHIFT;
            lba = LBA_W'({bytes[1][4:0], bytes[2], bytes[3]});
         end
         8'h28, 8'h2A: begin
            dir = (op == 8'h28) ? DIR_IN : DIR_OUT;
            len = LEN_W'({bytes[7], bytes[8]}) << BLK_SHIFT;
            lba = LBA_W'({bytes[2], bytes[3], bytes[4], bytes[5]});
         end
         default: unsup = 1'b1;
      endcase
   end

endmodule

// File: rtl/scsi_tgt_seq.sv
module scsi_tgt_seq
   import scsi_tgt_pkg::*;
#(
   parameter int ID_BIT    = 6,
   parameter int CDB_MAX   = 12,
   parameter int BLK_SHIFT = 9,
   parameter int LBA_W     = 32,
   localparam int CNT_W    = $clog2(CDB_MAX + 1),
   localparam int LEN_W    = 16 + BLK_SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rst_i,
   input  logic             sel_i,
   input  logic             atn_i,
   input  logic             ack_i,
   input  logic             ibsy_i,
   input  logic [7:0]       data_i,
   output logic [7:0]       data_o,
   output logic             bsy_o,
   output logic             req_o,
   output logic             msg_o,
   output logic             cd_o,
   output logic             io_o,
   input  logic             in_valid_i,
   input  logic [7:0]       in_data_i,
   output logic             in_ready_o,
   output logic             out_valid_o,
   output logic [7:0]       out_data_o,
   input  logic             out_ready_i,
   output logic [LBA_W-1:0] lba_o,
   output logic [LEN_W-1:0] xfer_len_o
);

   if (ID_BIT < 0 || ID_BIT > 7) begin : g_bad_id
      $error("ID_BIT must select a data bus line");
   end
   if (CDB_MAX < 12) begin : g_bad_cdb
      $error("CDB_MAX must hold a 12-byte descriptor");
   end
   if (LBA_W < 32) begin : g_bad_lba
      $error("LBA_W must hold a 32-bit block address");
   end

   tgt_state_t          state_q;
   logic                req_q, bsy_q;
   logic [7:0]          resp_q, din_q;
   logic [LEN_W-1:0]    cnt_q, len_q;
   logic [LBA_W-1:0]    lba_q;

   logic [CDB_MAX-1:0][7:0] cdb_bytes;
   logic [CNT_W-1:0]    cdb_cnt;
   logic                cdb_clr, cdb_wr, cdb_done, dec_unsup, dec_lun;
   xfer_dir_t           dec_dir;
   logic [LEN_W-1:0]    dec_len;
   logic [LBA_W-1:0]    dec_lba;
   logic                avail, xfer;
   logic [2:0]          phase;

   assign avail   = (state_q == ST_DIN) ? in_valid_i : 1'b1;
   assign xfer    = req_q && ack_i && (state_q != ST_DOUT || out_ready_i);
   assign cdb_clr = state_q inside {ST_FREE, ST_SELECT, ST_MSGOUT};
   assign cdb_wr  = (state_q == ST_CMD) && xfer;

   tgt_cdb_store #(.CDB_MAX(CDB_MAX)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(cdb_clr), .wr_en(cdb_wr),
      .wr_byte(data_i), .bytes(cdb_bytes), .cnt(cdb_cnt)
   );

   tgt_cdb_decode #(.CDB_MAX(CDB_MAX), .BLK_SHIFT(BLK_SHIFT), .LBA_W(LBA_W)) u_dec (
      .bytes(cdb_bytes), .cnt(cdb_cnt), .done(cdb_done), .dir(dec_dir),
      .len(dec_len), .lba(dec_lba), .unsup(dec_unsup), .lun_nz(dec_lun)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || bus_rst_i) begin
         state_q <= ST_FREE;
         req_q   <= 1'b0;
         bsy_q   <= 1'b0;
         resp_q  <= RESP_GOOD;
         din_q   <= '0;
         cnt_q   <= '0;
         len_q   <= '0;
         lba_q   <= '0;
      end else begin
         case (state_q)
            ST_FREE:
               if (sel_i && !ibsy_i && data_i[ID_BIT]) begin
                  state_q <= ST_SELECT;
                  bsy_q   <= 1'b1;
                  resp_q  <= RESP_GOOD;
               end
            ST_SELECT:
               if (!sel_i) state_q <= atn_i ? ST_MSGOUT : ST_CMD;
            default: begin
               if (state_q == ST_CMD && cdb_done && !req_q) begin
                  lba_q  <= dec_lba;
                  len_q  <= dec_len;
                  cnt_q  <= dec_len;
                  resp_q <= (dec_unsup || dec_lun) ? RESP_CHECK : RESP_GOOD;
                  if (dec_unsup || dec_dir == DIR_NONE || dec_len == '0)
                     state_q <= ST_STATUS;
                  else
                     state_q <= (dec_dir == DIR_IN) ? ST_DIN : ST_DOUT;
               end else if (!req_q && !ack_i && avail) begin
                  req_q <= 1'b1;
                  if (state_q == ST_DIN) din_q <= in_data_i;
               end else if (xfer) begin
                  req_q <= 1'b0;
                  case (state_q)
                     ST_MSGOUT: state_q <= ST_CMD;
                     ST_DIN, ST_DOUT: begin
                        cnt_q <= cnt_q - 1'b1;
                        if (cnt_q == LEN_W'(1)) state_q <= ST_STATUS;
                     end
                     ST_STATUS: state_q <= ST_MSGIN;
                     ST_MSGIN: begin
                        state_q <= ST_FREE;
                        bsy_q   <= 1'b0;
                     end
                     default: ;
                  endcase
               end
            end
         endcase
      end
   end

   assign phase = phase_code(state_q);
   assign {msg_o, cd_o, io_o} = phase;
   assign req_o       = req_q;
   assign bsy_o       = bsy_q;
   assign in_ready_o  = (state_q == ST_DIN) && !req_q && !ack_i;
   assign out_valid_o = (state_q == ST_DOUT) && req_q && ack_i;
   assign out_data_o  = data_i;
   assign lba_o       = lba_q;
   assign xfer_len_o  = len_q;

   always_comb begin
      case (state_q)
         ST_DIN:   data_o = din_q;
         ST_MSGIN: data_o = resp_q;
         default:  data_o = 8'h00;
      endcase
   end

   // R4
   req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o) |-> $past(!ack_i));
   // R4
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && ack_i && out_ready_i) |=> !req_o);
   // R11
   bus_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst_i |=> (!bsy_o && !req_o && {msg_o, cd_o, io_o} == 3'd0));
   // R9
   req_bsy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> bsy_o);
   // R1
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && $past(req_o)) |-> $stable({msg_o, cd_o, io_o}));
   // R12
   in_ready_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready_o |-> ({msg_o, cd_o, io_o} == 3'd1 && !req_o));

endmodule

// File: tb/scsi_tgt_seq_tb_top.sv
module scsi_tgt_seq_tb_top;

   localparam int ID = 6;

   logic clk = 0, rst_n = 0, bus_rst_i = 0, sel_i = 0, atn_i = 0, ack_i = 0, ibsy_i = 0;
   logic [7:0] data_i = 0, data_o, in_data_i = 0, out_data_o;
   logic bsy_o, req_o, msg_o, cd_o, io_o, in_valid_i = 1, in_ready_o, out_valid_o, out_ready_i = 1;
   logic [31:0] lba_o;
   logic [24:0] xfer_len_o;

   int checks = 0, fails = 0, cyc = 0, din_k = 0;
   bit stall_once = 0, done_flag = 0;
   logic [7:0] cdb [12];
   logic [2:0] exp_ph;
   int exp_len, exp_n;
   logic [7:0] exp_resp;
   logic [31:0] exp_lba;

   always #2 clk = ~clk;

   scsi_tgt_seq dut_i (
      .clk, .rst_n, .bus_rst_i, .sel_i, .atn_i, .ack_i, .ibsy_i, .data_i, .data_o,
      .bsy_o, .req_o, .msg_o, .cd_o, .io_o, .in_valid_i, .in_data_i, .in_ready_o,
      .out_valid_o, .out_data_o, .out_ready_i, .lba_o, .xfer_len_o
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done_flag) begin
         fails = fails + 1; checks = checks + 1;
         $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   function automatic logic [2:0] ph();
      return {msg_o, cd_o, io_o};
   endfunction

   function automatic logic [7:0] pat(input int k);
      return 8'((k * 7 + 3) ^ 8'h5A);
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // expected behaviour computed from the requirements
   function automatic void model();
      logic [7:0] op = cdb[0];
      logic [2:0] g = op[7:5];
      exp_n = (g == 0) ? 6 : (g == 1 || g == 2) ? 10 : (g == 5) ? 12 : 6;
      exp_resp = (cdb[1][7:5] != 0) ? 8'h02 : 8'h00;
      exp_ph = 3; exp_len = 0; exp_lba = 0;
      case (op)
         8'h00: ;
         8'h03, 8'h12, 8'h1A: begin exp_ph = 1; exp_len = cdb[4]; end
         8'h15: begin exp_ph = 0; exp_len = cdb[4]; end
         8'h25: begin exp_ph = 1; exp_len = 8; end
         8'h08: begin exp_ph = 1; exp_len = cdb[4] * 512;
            exp_lba = {11'd0, cdb[1][4:0], cdb[2], cdb[3]}; end
         8'h28, 8'h2A: begin exp_ph = (op == 8'h28) ? 3'd1 : 3'd0;
            exp_len = {cdb[7], cdb[8]} * 512;
            exp_lba = {cdb[2], cdb[3], cdb[4], cdb[5]}; end
         default: exp_resp = 8'h02;
      endcase
      if (exp_len == 0) exp_ph = 3;
   endfunction

   task automatic hs(input logic [7:0] drv, input logic [2:0] eph, input string tag,
                     output logic [7:0] seen);
      while (!req_o) @(negedge clk);
      chk(ph() == eph, tag, ph(), eph);
      seen = data_o;
      data_i = drv;
      ack_i = 1;
      if (eph == 3'd0) begin
         #1;
         chk(out_valid_o && out_data_o == drv, "R12 out port", out_data_o, drv);
         if (stall_once) begin
            out_ready_i = 0;
            @(negedge clk); @(negedge clk);
            chk(req_o == 1 && out_valid_o == 1, "R12 stall hold", req_o, 1);
            out_ready_i = 1;
            stall_once = 0;
         end
      end
      @(negedge clk);
      chk(req_o == 0, "R4 req drop", req_o, 0);
      ack_i = 0;
      if (eph == 3'd1) din_k++;
      in_data_i = pat(din_k);
      @(negedge clk);
   endtask

   task automatic select(input bit atn);
      data_i = 8'h80 | 8'(1 << ID);
      sel_i = 1; atn_i = atn;
      @(negedge clk); @(negedge clk);
      chk(bsy_o == 1, "R2 select", bsy_o, 1);
      sel_i = 0; data_i = 0;
      @(negedge clk);
   endtask

   task automatic run_cmd(input bit atn);
      logic [7:0] s;
      model();
      din_k = 0; in_data_i = pat(0);
      select(atn);
      if (atn) begin
         hs(8'h80, 3'd6, "R3 msgout", s);
         atn_i = 0;
      end
      for (int i = 0; i < exp_n; i++) hs(cdb[i], 3'd2, "R5 cmd phase", s);
      for (int k = 0; k < exp_len; k++) begin
         hs(pat(k), exp_ph, (exp_ph == 1) ? "R6 data-in" : "R6 data-out", s);
         if (exp_ph == 1) chk(s == pat(k), "R12 data-in byte", s, pat(k));
      end
      hs(8'h00, 3'd3, (exp_len == 0) ? "R10 status" : "R9 status", s);
      chk(s == 8'h00, "R9 status byte", s, 0);
      hs(8'h00, 3'd7, "R9 msgin", s);
      chk(s == exp_resp, "R8 response", s, exp_resp);
      chk(bsy_o == 0 && ph() == 0, "R9 bus free", bsy_o, 0);
      chk(lba_o == exp_lba, "R7 lba", lba_o, exp_lba);
      chk(xfer_len_o == 25'(exp_len), "R7 length", xfer_len_o, exp_len);
   endtask

   task automatic clear_cdb();
      for (int i = 0; i < 12; i++) cdb[i] = 0;
   endtask

   initial begin
      logic [7:0] s;
      logic [7:0] ops [9] = '{8'h00, 8'h03, 8'h12, 8'h1A, 8'h15, 8'h25, 8'h08, 8'h01, 8'h28};
      void'($urandom(32'd4711));
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(bsy_o == 0 && req_o == 0 && ph() == 0, "R1 reset state", {bsy_o, req_o, ph()}, 0);

      // wrong ID and busy initiator are ignored
      data_i = 8'hA0; sel_i = 1;
      repeat (3) @(negedge clk);
      chk(bsy_o == 0, "R2 wrong id", bsy_o, 0);
      data_i = 8'hC0; ibsy_i = 1;
      repeat (3) @(negedge clk);
      chk(bsy_o == 0, "R2 initiator busy", bsy_o, 0);
      sel_i = 0; ibsy_i = 0; data_i = 0;
      @(negedge clk);

      // selection without attention enters command
      clear_cdb();
      run_cmd(0);
      // with attention, message-out first
      clear_cdb(); cdb[0] = 8'h12; cdb[4] = 8'd5;
      run_cmd(1);
      clear_cdb(); cdb[0] = 8'h12; cdb[1] = 8'h20; cdb[4] = 8'd3;
      run_cmd(1);
      clear_cdb(); cdb[0] = 8'h01;
      run_cmd(0);
      clear_cdb(); cdb[0] = 8'h08; cdb[1] = 8'h13; cdb[2] = 8'hA5; cdb[3] = 8'h3C;
      run_cmd(0);
      clear_cdb(); cdb[0] = 8'h28; cdb[2] = 8'h12; cdb[3] = 8'h34; cdb[4] = 8'h56;
      cdb[5] = 8'h78; cdb[8] = 8'h01;
      run_cmd(1);
      clear_cdb(); cdb[0] = 8'h2A; cdb[2] = 8'h80; cdb[5] = 8'h09; cdb[8] = 8'h01;
      stall_once = 1;
      run_cmd(1);
      clear_cdb(); cdb[0] = 8'h25;
      run_cmd(0);
      clear_cdb(); cdb[0] = 8'h15; cdb[4] = 8'd3;
      run_cmd(0);
      clear_cdb(); cdb[0] = 8'hA8; cdb[9] = 8'h01;
      run_cmd(0);
      clear_cdb(); cdb[0] = 8'hE0;
      run_cmd(0);
      clear_cdb(); cdb[0] = 8'h28;
      run_cmd(0);

      // R11 bus reset in the middle of a data-in transfer
      clear_cdb(); cdb[0] = 8'h28; cdb[8] = 8'h01;
      din_k = 0; in_data_i = pat(0);
      select(0);
      for (int i = 0; i < 10; i++) hs(cdb[i], 3'd2, "R5 cmd phase", s);
      for (int k = 0; k < 3; k++) hs(8'h00, 3'd1, "R11 pre data", s);
      bus_rst_i = 1;
      @(negedge clk);
      chk(bsy_o == 0 && req_o == 0 && ph() == 0, "R11 bus reset", {bsy_o, req_o, ph()}, 0);
      bus_rst_i = 0;
      @(negedge clk);

      // constrained random commands
      for (int it = 0; it < 24; it++) begin
         clear_cdb();
         cdb[0] = ops[$urandom_range(0, 8)];
         cdb[1] = 8'($urandom_range(0, 31));
         if ($urandom_range(0, 3) == 0) cdb[1][7:5] = 3'($urandom_range(1, 7));
         cdb[2] = 8'($urandom_range(0, 255));
         cdb[3] = 8'($urandom_range(0, 255));
         cdb[4] = (cdb[0] == 8'h08) ? 8'($urandom_range(0, 1)) : 8'($urandom_range(0, 6));
         cdb[5] = 8'($urandom_range(0, 255));
         cdb[8] = 8'($urandom_range(0, 1));
         run_cmd(1'($urandom_range(0, 1)));
      end

      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule